// File: doc/BRIEF.md
# Prioritized Chip-Select Bank Decoder

This block decides which of a small set of programmable memory banks serves an external bus request. Each bank is described by two configuration words. The base word holds a base address, an expected address-type code, a write-protect bit and a valid bit. The option word holds an address mask and an address-type mask. When a request strobe arrives, the block compares every bank against the request. It picks the lowest-numbered bank that hits and drives a registered one-hot chip select, the bank index, a match flag and an internal acknowledge enable.

A write aimed at a write-protected bank is excluded from selection. The write still records a sticky violation bit for that bank. When no bank is chosen, the internal acknowledge stays low, so the cycle has to be ended by external transfer-acknowledge logic or by a bus-timeout monitor. Requests issued by an external master see their address type replaced by the fixed code 3'b100. Software programs the banks through a simple write port, reads the violation bits as a port, and clears them by writing ones.

Top module: `csel_decoder`

## Requirements
- R1: Bank i hits only when (addr_i[31:8] XOR base[31:8]) AND opt[31:8] is zero. Base word of bank i is at cfg_addr 2*i and option word at cfg_addr 2*i+1.
- R2: The type field base[3:1] is compared with the effective type under the mask opt[3:1]. A zero mask makes the type irrelevant for that bank.
- R3: When several banks hit, cs_o is one-hot on the lowest index and bank_idx_o carries that index.
- R4: base[4] is write protect. A write (wr_i=1) to a protected bank produces no chip select for it. A read of that bank is selected normally.
- R5: A write that hits a protected bank sets viol_o[i]. The bit stays set until it is cleared.
- R6: ack_en_o and match_o are high exactly when a bank is selected. They stay low on a miss or on a protected write.
- R7: When ext_mst_i is high, the comparison uses type 3'b100 regardless of at_i.
- R8: A bank whose valid bit base[0] is 0 never hits.
- R9: A write to cfg_addr 8 clears every viol_o bit whose wdata bit is 1. A violation raised in the same cycle keeps its bit set.
- R10: cs_o changes on the first clock edge with req_i high. It keeps that value while req_i stays high, even if the inputs or the configuration change, and returns to zero on the first edge with req_i low.
- R11: After reset all outputs are zero and every bank is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, held for the whole cycle |
| addr_i | input | 32 | Request address |
| at_i | input | 3 | Address-type code |
| wr_i | input | 1 | 1 = write, 0 = read |
| ext_mst_i | input | 1 | Request issued by an external master |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| cs_o | output | 4 | Registered one-hot chip select |
| bank_idx_o | output | 2 | Index of the selected bank |
| match_o | output | 1 | A bank is selected |
| ack_en_o | output | 1 | Internal acknowledge enable |
| viol_o | output | 4 | Sticky write-protect violation bits |

## Verification
A corrupted base or option word shows up as a wrong or missing chip select on the first request that reaches the affected bank, one edge after the strobe. A broken priority chain or protect gate shows up the same way. A lost hold state changes cs_o in the middle of a request, and a leaky sticky bit makes viol_o drop without a clear. Either fault is visible on the cycle it happens, because a behavioural model is compared with every output on every clock.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int WORD_W   = 32;
  localparam int ADDR_LSB = 8;
  localparam int AT_W     = 3;
  localparam int VLD_BIT  = 0;
  localparam int AT_LO    = 1;
  localparam int WP_BIT   = 4;
  localparam logic [AT_W-1:0] EXT_AT = 3'b100;

  // address hit under the option mask
  function automatic logic addr_hit(input logic [WORD_W-1:0] addr,
                                    input logic [WORD_W-1:0] base,
                                    input logic [WORD_W-1:0] opt);
    return ((addr[WORD_W-1:ADDR_LSB] ^ base[WORD_W-1:ADDR_LSB])
            & opt[WORD_W-1:ADDR_LSB]) == '0;
  endfunction

  // type hit under the type mask; zero mask always hits
  function automatic logic type_hit(input logic [AT_W-1:0]   at,
                                    input logic [WORD_W-1:0] base,
                                    input logic [WORD_W-1:0] opt);
    return ((at ^ base[AT_LO+AT_W-1:AT_LO]) & opt[AT_LO+AT_W-1:AT_LO]) == '0;
  endfunction
endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
#(
  parameter int NBANK = 4,
  localparam int CAW  = $clog2(2*NBANK+1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CAW-1:0]                cfg_addr,
  input  logic [WORD_W-1:0]             cfg_wdata,
  input  logic [NBANK-1:0]              viol_set,
  output logic [NBANK-1:0][WORD_W-1:0]  base_o,
  output logic [NBANK-1:0][WORD_W-1:0]  opt_o,
  output logic [NBANK-1:0]              viol_o,
  output logic [NBANK-1:0]              clr_vec
);
  localparam int STAT_ADDR = 2*NBANK;

  assign clr_vec = (cfg_we && cfg_addr == CAW'(STAT_ADDR)) ? cfg_wdata[NBANK-1:0] : '0;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_o[b] <= '0;
        opt_o[b]  <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == CAW'(2*b))   base_o[b] <= cfg_wdata;
        if (cfg_addr == CAW'(2*b+1)) opt_o[b]  <= cfg_wdata;
      end
    end

    // a new violation beats a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           viol_o[b] <= 1'b0;
      else if (viol_set[b]) viol_o[b] <= 1'b1;
      else if (clr_vec[b])  viol_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/csel_bank_cmp.sv
module csel_bank_cmp
  import csel_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic [WORD_W-1:0]             addr_i,
  input  logic [AT_W-1:0]               at_eff,
  input  logic                          wr_i,
  input  logic [NBANK-1:0][WORD_W-1:0]  base_i,
  input  logic [NBANK-1:0][WORD_W-1:0]  opt_i,
  output logic [NBANK-1:0]              hit_vec,
  output logic [NBANK-1:0]              prot_vec,
  output logic [NBANK-1:0]              wp_vec
);
  for (genvar b = 0; b < NBANK; b++) begin : g_cmp
    logic raw_hit;
    logic unused_fields;
    assign unused_fields = ^{base_i[b][7:5], opt_i[b][7:4], opt_i[b][0]};
    assign raw_hit     = base_i[b][VLD_BIT]
                       && addr_hit(addr_i, base_i[b], opt_i[b])
                       && type_hit(at_eff, base_i[b], opt_i[b]);
    assign wp_vec[b]   = base_i[b][WP_BIT];
    assign prot_vec[b] = raw_hit && wr_i && wp_vec[b];
    assign hit_vec[b]  = raw_hit && !(wr_i && wp_vec[b]);
  end
endmodule

// File: rtl/csel_prio.sv
module csel_prio #(
  parameter int NBANK = 4,
  localparam int IDXW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic [NBANK-1:0] hit_vec,
  output logic [NBANK-1:0] onehot,
  output logic [IDXW-1:0]  idx,
  output logic             any
);
  // scan from the top so the lowest index is written last
  always_comb begin
    onehot = '0;
    idx    = '0;
    any    = 1'b0;
    for (int i = NBANK-1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        onehot    = '0;
        onehot[i] = 1'b1;
        idx       = IDXW'(i);
        any       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
#(
  parameter int NBANK = 4,
  localparam int IDXW = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int CAW  = $clog2(2*NBANK+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [31:0]       addr_i,
  input  logic [2:0]        at_i,
  input  logic              wr_i,
  input  logic              ext_mst_i,
  input  logic              cfg_we,
  input  logic [CAW-1:0]    cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [NBANK-1:0]  cs_o,
  output logic [IDXW-1:0]   bank_idx_o,
  output logic              match_o,
  output logic              ack_en_o,
  output logic [NBANK-1:0]  viol_o
);
  logic [NBANK-1:0][WORD_W-1:0] base_w, opt_w;
  logic [NBANK-1:0] hit_vec, prot_vec, wp_vec, onehot_w, viol_set_w, clr_vec;
  logic [IDXW-1:0]  idx_w;
  logic             any_w;
  logic [AT_W-1:0]  at_eff;
  logic             busy_q, decode_w, hold_w;

  assign at_eff     = ext_mst_i ? EXT_AT : at_i;
  assign decode_w   = req_i && !busy_q;
  assign hold_w     = req_i && busy_q;
  assign viol_set_w = decode_w ? prot_vec : '0;

  csel_regs #(.NBANK(NBANK)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .viol_set(viol_set_w), .base_o(base_w),
    .opt_o(opt_w), .viol_o(viol_o), .clr_vec(clr_vec)
  );

  csel_bank_cmp #(.NBANK(NBANK)) u_cmp (
    .addr_i(addr_i), .at_eff(at_eff), .wr_i(wr_i), .base_i(base_w),
    .opt_i(opt_w), .hit_vec(hit_vec), .prot_vec(prot_vec), .wp_vec(wp_vec)
  );

  csel_prio #(.NBANK(NBANK)) u_prio (
    .hit_vec(hit_vec), .onehot(onehot_w), .idx(idx_w), .any(any_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cs_o       <= '0;
      bank_idx_o <= '0;
      match_o    <= 1'b0;
      ack_en_o   <= 1'b0;
    end else if (!req_i) begin
      busy_q     <= 1'b0;
      cs_o       <= '0;
      bank_idx_o <= '0;
      match_o    <= 1'b0;
      ack_en_o   <= 1'b0;
    end else if (decode_w) begin
      busy_q     <= 1'b1;
      cs_o       <= onehot_w;
      bank_idx_o <= idx_w;
      match_o    <= any_w;
      ack_en_o   <= any_w;
    end
  end
endmodule

// File: rtl/csel_decoder_chk.sv
module csel_decoder_chk #(
  parameter int NBANK = 4,
  localparam int IDXW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic             wr_i,
  input logic             decode_w,
  input logic             hold_w,
  input logic [NBANK-1:0] wp_vec,
  input logic [NBANK-1:0] viol_set_w,
  input logic [NBANK-1:0] clr_vec,
  input logic [NBANK-1:0] cs_o,
  input logic [IDXW-1:0]  bank_idx_o,
  input logic             match_o,
  input logic             ack_en_o,
  input logic [NBANK-1:0] viol_o
);
  p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o));
  p_idx_points_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> cs_o[bank_idx_o]);
  p_ack_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en_o |-> (cs_o != '0));
  p_no_prot_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_w && wr_i) |=> ((cs_o & $past(wp_vec)) == '0));
  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (cs_o == '0 && !match_o));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_w |=> $stable(cs_o));
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((viol_o & $past(viol_set_w)) == $past(viol_set_w)));
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> ((viol_o & $past(viol_o)) == $past(viol_o)));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((viol_o & $past(clr_vec) & ~$past(viol_set_w)) == '0));
endmodule

bind csel_decoder csel_decoder_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i),
  .decode_w(decode_w), .hold_w(hold_w), .wp_vec(wp_vec),
  .viol_set_w(viol_set_w), .clr_vec(clr_vec), .cs_o(cs_o),
  .bank_idx_o(bank_idx_o), .match_o(match_o), .ack_en_o(ack_en_o),
  .viol_o(viol_o)
);

// File: tb/tb_csel_decoder.sv
module tb_csel_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [2:0]  at_i = '0;
  logic        wr_i = 1'b0;
  logic        ext_mst_i = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cs_o;
  logic [1:0]  bank_idx_o;
  logic        match_o, ack_en_o;
  logic [3:0]  viol_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csel_decoder dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .at_i(at_i),
    .wr_i(wr_i), .ext_mst_i(ext_mst_i), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cs_o(cs_o), .bank_idx_o(bank_idx_o),
    .match_o(match_o), .ack_en_o(ack_en_o), .viol_o(viol_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_base [4];
  logic [31:0] m_opt  [4];
  logic [3:0]  m_viol, m_cs;
  logic        m_busy, m_match;
  int          m_idx;

  always @(posedge clk) begin
    logic [3:0] vset, clr;
    logic [2:0] at;
    int sel;
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) begin m_base[b] = '0; m_opt[b] = '0; end
      m_viol = '0; m_cs = '0; m_busy = 0; m_match = 0; m_idx = 0;
    end else begin
      vset = '0;
      if (!req_i) begin
        m_cs = '0; m_busy = 0; m_match = 0; m_idx = 0;
      end else if (!m_busy) begin
        at = ext_mst_i ? 3'd4 : at_i;
        sel = -1;
        for (int b = 0; b < 4; b++) begin
          if (m_base[b][0]
              && ((addr_i[31:8] ^ m_base[b][31:8]) & m_opt[b][31:8]) == 0
              && ((at ^ m_base[b][3:1]) & m_opt[b][3:1]) == 0) begin
            if (wr_i && m_base[b][4]) vset[b] = 1'b1;
            else if (sel < 0) sel = b;
          end
        end
        m_busy = 1;
        m_match = (sel >= 0);
        m_idx = (sel >= 0) ? sel : 0;
        m_cs = (sel >= 0) ? 4'(1 << sel) : 4'b0;
      end
      clr = (cfg_we && cfg_addr == 4'd8) ? cfg_wdata[3:0] : 4'b0;
      m_viol = (m_viol & ~clr) | vset;
      if (cfg_we && cfg_addr < 4'd8) begin
        if (cfg_addr[0]) m_opt[cfg_addr[3:1]] = cfg_wdata;
        else             m_base[cfg_addr[3:1]] = cfg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 model cs", {28'b0, cs_o}, {28'b0, m_cs});
      chk("R3 model idx", {30'b0, bank_idx_o}, 32'(m_idx));
      chk("R6 model match", {31'b0, match_o}, {31'b0, m_match});
      chk("R6 model ack", {31'b0, ack_en_o}, {31'b0, m_match});
      chk("R5 model viol", {28'b0, viol_o}, {28'b0, m_viol});
    end
  end

  task automatic wcfg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic start_req(input logic [31:0] a, input logic [2:0] t,
                           input logic w, input logic e);
    @(negedge clk);
    addr_i = a; at_i = t; wr_i = w; ext_mst_i = e; req_i = 1;
    #1 chk("R10 no cs before edge", {28'b0, cs_o}, 32'h0);
    @(negedge clk);
  endtask

  task automatic end_req();
    req_i = 0;
    @(negedge clk);
    chk("R10 cs drops", {28'b0, cs_o}, 32'h0);
  endtask

  task automatic expect_sel(input string tag, input logic [3:0] cs, input logic [1:0] idx);
    chk(tag, {28'b0, cs_o}, {28'b0, cs});
    if (cs != 0) chk(tag, {30'b0, bank_idx_o}, {30'b0, idx});
    chk(tag, {31'b0, ack_en_o}, {31'b0, cs != 0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset cs", {28'b0, cs_o}, 0);
    chk("R11 reset viol", {28'b0, viol_o}, 0);
    chk("R11 reset ack", {31'b0, ack_en_o}, 0);
    start_req(32'h1000_1234, 3'd0, 1'b0, 1'b0);
    expect_sel("R8 invalid after reset", 4'b0000, 2'd0);
    end_req();

    wcfg(4'd0, 32'h1000_0001); wcfg(4'd1, 32'hFFFF_0000);
    wcfg(4'd2, 32'h1000_0001); wcfg(4'd3, 32'hF000_0000);
    wcfg(4'd4, 32'h2000_000B); wcfg(4'd5, 32'hFF00_000E);
    wcfg(4'd6, 32'h3000_0011); wcfg(4'd7, 32'hFF00_0000);

    start_req(32'h1000_1234, 3'd7, 1'b0, 1'b0);
    expect_sel("R3 lowest wins / R2 zero mask", 4'b0001, 2'd0);
    end_req();
    start_req(32'h1800_0000, 3'd0, 1'b0, 1'b0);
    expect_sel("R1 mask selects bank1", 4'b0010, 2'd1);
    end_req();
    start_req(32'h2000_0040, 3'd5, 1'b0, 1'b0);
    expect_sel("R2 type hit", 4'b0100, 2'd2);
    end_req();
    start_req(32'h2000_0040, 3'd4, 1'b0, 1'b0);
    expect_sel("R2 type miss R6", 4'b0000, 2'd0);
    end_req();
    start_req(32'h2000_0040, 3'd5, 1'b0, 1'b1);
    expect_sel("R7 forced type misses", 4'b0000, 2'd0);
    end_req();
    wcfg(4'd4, 32'h2000_0009);
    start_req(32'h2000_0040, 3'd0, 1'b0, 1'b1);
    expect_sel("R7 forced type hits", 4'b0100, 2'd2);
    // R10 hold despite new inputs and config
    addr_i = 32'h9000_0000; wcfg(4'd4, 32'h2000_0008);
    expect_sel("R10 held", 4'b0100, 2'd2);
    end_req();
    wcfg(4'd4, 32'h2000_0009);

    start_req(32'h3000_0000, 3'd0, 1'b0, 1'b0);
    expect_sel("R4 protected read", 4'b1000, 2'd3);
    end_req();
    start_req(32'h3000_0000, 3'd0, 1'b1, 1'b0);
    expect_sel("R4 protected write R6", 4'b0000, 2'd0);
    chk("R5 violation set", {28'b0, viol_o}, 32'h8);
    end_req();
    start_req(32'h1000_0000, 3'd0, 1'b1, 1'b0);
    expect_sel("R4 unprotected write", 4'b0001, 2'd0);
    chk("R5 sticky", {28'b0, viol_o}, 32'h8);
    end_req();
    wcfg(4'd8, 32'h0000_0007);
    chk("R9 other bits only", {28'b0, viol_o}, 32'h8);
    wcfg(4'd8, 32'h0000_0008);
    chk("R9 clear", {28'b0, viol_o}, 32'h0);

    @(negedge clk);
    addr_i = 32'h3000_0000; wr_i = 1; ext_mst_i = 0; req_i = 1;
    cfg_we = 1; cfg_addr = 4'd8; cfg_wdata = 32'hF;
    @(negedge clk); cfg_we = 0;
    chk("R9 set beats clear", {28'b0, viol_o}, 32'h8);
    end_req();
    wcfg(4'd8, 32'hF);

    wcfg(4'd0, 32'h1000_0000);
    start_req(32'h1000_1234, 3'd0, 1'b0, 1'b0);
    expect_sel("R8 invalid bank0 skipped", 4'b0010, 2'd1);
    end_req();
    wcfg(4'd2, 32'h1000_0000);
    start_req(32'h1000_1234, 3'd0, 1'b0, 1'b0);
    expect_sel("R8 all invalid", 4'b0000, 2'd0);
    chk("R6 no match", {31'b0, match_o}, 0);
    end_req();

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule